// File: doc/BRIEF.md
# Four-Level Symbol Slicer with Decision Feedback and Per-Eye Skew

This block sits behind an ADC in a four-level (PAM-4) receiver and turns one signed sample per symbol into a 2-bit symbol decision. Three comparators separate the four nominal levels: -3, -1, +1 and +3. The upper comparator sits between +1 and +3, the centre one between -1 and +1, and the lower one between -3 and -1. Before each comparison, a two-tap decision-feedback term moves all three thresholds up or down. The term is built from the two most recent decisions. Each comparator may look at the current sample or at one up to three symbols older. Eyes that are skewed against each other can therefore each be sampled at their own instant.

Samples enter on `in_valid` into a four-deep sample line. A two-state controller holds the block in `ST_FILL` until the line holds four accepted samples. The fourth accepted sample after reset takes the transition `ST_FILL -> ST_RUN`. The block then stays in `ST_RUN` until reset. In `ST_RUN` every accepted sample yields one decision, two clock edges later. The thresholds, skew selects, tap weights and the output-coding bit are all taken with the accepted sample. Changes made between samples therefore take effect at the next symbol.

Top module: `pam4_dfe_slicer`

## Requirements
- R1: After reset, `sym_valid` is 0, `code_err` is 0 and `sym_out` is 0.
- R2: The first three accepted samples after reset produce no output. The fourth accepted sample and every later one produce a one-cycle `sym_valid` pulse, two rising edges after the edge that accepted the sample.
- R3: An eye's comparator is set when its sample is greater than or equal to its effective threshold. The comparator bits (upper, centre, lower) decode 000 to symbol 0, 001 to symbol 1, 011 to symbol 2 and 111 to symbol 3.
- R4: Any other comparator pattern yields symbol 2 if the centre comparator is set and symbol 1 otherwise. Such a pattern also sets `code_err`, which stays set until reset.
- R5: An eye whose skew select is k (0 to 3) compares the sample accepted k samples before the current one.
- R6: The correction is sat(w1·L1 + w2·L2). L1 is the level of the newest emitted decision and L2 the level of the one before it. Symbols 0, 1, 2 and 3 have the levels -3, -1, +1 and +3. A decision that has not yet been emitted since reset counts as 0.
- R7: Each effective threshold is sat(threshold + correction). sat clamps to the signed 12-bit range [-2048, 2047].
- R8: With `plain_bin` = 0 the output is Gray coded: 0→00, 1→01, 2→11, 3→10. With `plain_bin` = 1 the symbol number is output unchanged.
- R9: The thresholds, skews, weights and `plain_bin` used for a decision are the values present in the cycle that sample was accepted. Values present on other cycles have no effect on that decision.
- R10: While `in_valid` is low, the sample line and the decision history hold their values and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accepts `in_sample` this cycle |
| in_sample | input | 12 | Signed ADC sample |
| thr_top | input | 12 | Signed upper threshold |
| thr_mid | input | 12 | Signed centre threshold |
| thr_bot | input | 12 | Signed lower threshold |
| skew_top | input | 2 | Sample age seen by the upper comparator |
| skew_mid | input | 2 | Sample age seen by the centre comparator |
| skew_bot | input | 2 | Sample age seen by the lower comparator |
| tap_w1 | input | 12 | Signed weight of the newest decision |
| tap_w2 | input | 12 | Signed weight of the older decision |
| plain_bin | input | 1 | 1: binary output, 0: Gray output |
| sym_out | output | 2 | Decided symbol code |
| sym_valid | output | 1 | `sym_out` holds a new decision |
| code_err | output | 1 | Sticky flag for an inconsistent comparator pattern |

## Verification
A decision that falls back to the centre comparator is fed back in the same cycle as a normal decision. The fallback sets the sticky flag and also becomes L1 of the feedback history for the next symbol. Both effects therefore land on the same edge. The bench provokes this by streaming back-to-back samples with random skews, inverted thresholds and non-zero tap weights. It then compares the next decision and the flag against a model that takes the fallback symbol as history.

// File: rtl/pam4_slicer_pkg.sv
package pam4_slicer_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } slicer_state_e;

    function automatic logic signed [2:0] sym_level(input logic [1:0] s);
        unique case (s)
            2'd0:    return -3'sd3;
            2'd1:    return -3'sd1;
            2'd2:    return 3'sd1;
            default: return 3'sd3;
        endcase
    endfunction

    function automatic logic [1:0] sym_code(input logic [1:0] s, input logic plain);
        if (plain) return s;
        return {s[1], s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/pam4_skew_line.sv
module pam4_skew_line #(
    parameter  int SW    = 12,
    parameter  int DEPTH = 4,
    localparam int SELW  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift,
    input  logic signed [SW-1:0]  din,
    input  logic [SELW-1:0]       sel_top,
    input  logic [SELW-1:0]       sel_mid,
    input  logic [SELW-1:0]       sel_bot,
    output logic signed [SW-1:0]  out_top,
    output logic signed [SW-1:0]  out_mid,
    output logic signed [SW-1:0]  out_bot
);

    logic signed [SW-1:0] line [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line[g] <= '0;
            end else if (shift) begin
                if (g == 0) line[g] <= din;
                else        line[g] <= line[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign out_top = line[sel_top];
    assign out_mid = line[sel_mid];
    assign out_bot = line[sel_bot];

    // R10: an idle cycle leaves the oldest stored sample untouched
    a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(line[DEPTH-1]));

    if (DEPTH > 1) begin : g_step_chk
        // R5: each accepted sample moves one position deeper
        a_r5_line_step: assert property (@(posedge clk) disable iff (!rst_n)
            shift |=> line[1] == $past(line[0]));
    end

endmodule

// File: rtl/pam4_dfe_corr.sv
module pam4_dfe_corr #(
    parameter  int SW = 12,
    localparam int WW = SW + 4
) (
    input  logic signed [2:0]    lvl1,
    input  logic signed [2:0]    lvl2,
    input  logic signed [SW-1:0] w1,
    input  logic signed [SW-1:0] w2,
    output logic signed [SW-1:0] corr
);

    localparam logic signed [WW-1:0] HI = WW'((64'sd1 <<< (SW-1)) - 64'sd1);
    localparam logic signed [WW-1:0] LO = ~HI;

    logic signed [WW-1:0] p1, p2, sum;

    always_comb begin
        p1  = WW'(w1) * WW'(lvl1);
        p2  = WW'(w2) * WW'(lvl2);
        sum = p1 + p2;
        if (sum > HI)      corr = HI[SW-1:0];
        else if (sum < LO) corr = LO[SW-1:0];
        else               corr = sum[SW-1:0];
    end

endmodule

// File: rtl/pam4_decide.sv
module pam4_decide #(
    parameter int SW = 12
) (
    input  logic signed [SW-1:0] s_top,
    input  logic signed [SW-1:0] s_mid,
    input  logic signed [SW-1:0] s_bot,
    input  logic signed [SW-1:0] th_top,
    input  logic signed [SW-1:0] th_mid,
    input  logic signed [SW-1:0] th_bot,
    input  logic signed [SW-1:0] corr,
    output logic [1:0]           sym,
    output logic                 incons
);

    localparam logic signed [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};

    function automatic logic signed [SW-1:0] sat_add(input logic signed [SW-1:0] a,
                                                     input logic signed [SW-1:0] b);
        logic signed [SW:0] s;
        s = (SW+1)'(a) + (SW+1)'(b);
        if (s[SW] != s[SW-1]) return s[SW] ? MINV : MAXV;
        return s[SW-1:0];
    endfunction

    logic signed [SW-1:0] eff_top, eff_mid, eff_bot;
    logic                 c_top, c_mid, c_bot;

    always_comb begin
        eff_top = sat_add(th_top, corr);
        eff_mid = sat_add(th_mid, corr);
        eff_bot = sat_add(th_bot, corr);
        c_top   = (s_top >= eff_top);
        c_mid   = (s_mid >= eff_mid);
        c_bot   = (s_bot >= eff_bot);
        incons  = 1'b0;
        unique case ({c_top, c_mid, c_bot})
            3'b000:  sym = 2'd0;
            3'b001:  sym = 2'd1;
            3'b011:  sym = 2'd2;
            3'b111:  sym = 2'd3;
            default: begin
                sym    = c_mid ? 2'd2 : 2'd1;
                incons = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pam4_dfe_slicer.sv
module pam4_dfe_slicer
    import pam4_slicer_pkg::*;
#(
    parameter  int SW    = 12,
    parameter  int DEPTH = 4,
    localparam int SELW  = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_sample,
    input  logic signed [SW-1:0] thr_top,
    input  logic signed [SW-1:0] thr_mid,
    input  logic signed [SW-1:0] thr_bot,
    input  logic [SELW-1:0]      skew_top,
    input  logic [SELW-1:0]      skew_mid,
    input  logic [SELW-1:0]      skew_bot,
    input  logic signed [SW-1:0] tap_w1,
    input  logic signed [SW-1:0] tap_w2,
    input  logic                 plain_bin,
    output logic [1:0]           sym_out,
    output logic                 sym_valid,
    output logic                 code_err
);

    localparam logic [SELW-1:0] LAST_FILL = SELW'(DEPTH - 1);

    slicer_state_e        state_q, state_d;
    logic [SELW-1:0]      fill_q, fill_d;
    logic                 emit_d, emit_q;

    logic signed [SW-1:0] thr_top_q, thr_mid_q, thr_bot_q;
    logic [SELW-1:0]      skew_top_q, skew_mid_q, skew_bot_q;
    logic signed [SW-1:0] w1_q, w2_q;
    logic                 plain_q;

    logic signed [2:0]    hist1_q, hist2_q;
    logic signed [SW-1:0] smp_top, smp_mid, smp_bot, corr;
    logic [1:0]           dec_sym;
    logic                 dec_incons;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // next state and fill outputs
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        emit_d  = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (in_valid) begin
                    if (fill_q == LAST_FILL) begin
                        state_d = ST_RUN;
                        emit_d  = 1'b1;
                    end else begin
                        fill_d = fill_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                emit_d = in_valid;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // per-symbol settings taken with the accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q     <= 1'b0;
            thr_top_q  <= '0;
            thr_mid_q  <= '0;
            thr_bot_q  <= '0;
            skew_top_q <= '0;
            skew_mid_q <= '0;
            skew_bot_q <= '0;
            w1_q       <= '0;
            w2_q       <= '0;
            plain_q    <= 1'b0;
        end else begin
            emit_q <= emit_d;
            if (in_valid) begin
                thr_top_q  <= thr_top;
                thr_mid_q  <= thr_mid;
                thr_bot_q  <= thr_bot;
                skew_top_q <= skew_top;
                skew_mid_q <= skew_mid;
                skew_bot_q <= skew_bot;
                w1_q       <= tap_w1;
                w2_q       <= tap_w2;
                plain_q    <= plain_bin;
            end
        end
    end

    pam4_skew_line #(.SW(SW), .DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (in_valid),
        .din     (in_sample),
        .sel_top (skew_top_q),
        .sel_mid (skew_mid_q),
        .sel_bot (skew_bot_q),
        .out_top (smp_top),
        .out_mid (smp_mid),
        .out_bot (smp_bot)
    );

    pam4_dfe_corr #(.SW(SW)) u_corr (
        .lvl1 (hist1_q),
        .lvl2 (hist2_q),
        .w1   (w1_q),
        .w2   (w2_q),
        .corr (corr)
    );

    pam4_decide #(.SW(SW)) u_decide (
        .s_top  (smp_top),
        .s_mid  (smp_mid),
        .s_bot  (smp_bot),
        .th_top (thr_top_q),
        .th_mid (thr_mid_q),
        .th_bot (thr_bot_q),
        .corr   (corr),
        .sym    (dec_sym),
        .incons (dec_incons)
    );

    // decision register and feedback history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_out   <= '0;
            sym_valid <= 1'b0;
            code_err  <= 1'b0;
            hist1_q   <= '0;
            hist2_q   <= '0;
        end else begin
            sym_valid <= emit_q;
            if (emit_q) begin
                sym_out  <= sym_code(dec_sym, plain_q);
                hist1_q  <= sym_level(dec_sym);
                hist2_q  <= hist1_q;
                code_err <= code_err | dec_incons;
            end
        end
    end

    // R2: every output pulse traces back to a sample accepted two edges earlier
    a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(in_valid, 2));

    // R2: no output while the sample line is still filling
    a_r2_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> state_q == ST_RUN);

    // R10: an idle input cycle yields no output two edges later
    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !sym_valid);

    // R4: the error flag never clears by itself
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

    // R4: the error flag rises only together with an emitted decision
    a_r4_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_err) |-> sym_valid);

endmodule

// File: tb/pam4_dfe_slicer_bench.sv
module pam4_dfe_slicer_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic signed [11:0] thr_top = '0, thr_mid = '0, thr_bot = '0;
    logic [1:0]        skew_top = '0, skew_mid = '0, skew_bot = '0;
    logic signed [11:0] tap_w1 = '0, tap_w2 = '0;
    logic              plain_bin = 1'b0;
    logic [1:0]        sym_out;
    logic              sym_valid;
    logic              code_err;

    always #4 clk = ~clk;

    pam4_dfe_slicer u_pam4_dfe_slicer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .thr_top(thr_top), .thr_mid(thr_mid), .thr_bot(thr_bot),
        .skew_top(skew_top), .skew_mid(skew_mid), .skew_bot(skew_bot),
        .tap_w1(tap_w1), .tap_w2(tap_w2), .plain_bin(plain_bin),
        .sym_out(sym_out), .sym_valid(sym_valid), .code_err(code_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // current settings driven on each step
    int c_tt, c_tm, c_tb, c_st, c_sm, c_sb, c_w1, c_w2, c_pl;

    // bench model state
    int mdl [4];
    int mfill, mh1, mh2, merr;

    // expected pipeline: d1 = driven one step ago, d2 = two steps ago
    bit d1_v, d2_v;
    int d1_code, d2_code, d1_err, d2_err;
    string d1_tag, d2_tag;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int lvl(input int s);
        return 2 * s - 3;
    endfunction

    function automatic int rnd12();
        return int'($urandom % 4096) - 2048;
    endfunction

    function automatic int rnd_rng(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) mdl[k] = 0;
        mfill = 0; mh1 = 0; mh2 = 0; merr = 0;
        d1_v = 0; d2_v = 0; d1_err = 0; d2_err = 0;
        d1_code = 0; d2_code = 0; d1_tag = "R1"; d2_tag = "R1";
    endtask

    // model of one accepted sample; returns emit flag and code
    task automatic model_accept(input int smp, output bit emit, output int code);
        int corr, et, em, eb, t, m, b, s;
        for (int k = 3; k > 0; k--) mdl[k] = mdl[k-1];
        mdl[0] = smp;
        if (mfill < 4) mfill++;
        emit = (mfill == 4);
        code = 0;
        if (emit) begin
            corr = sat12(c_w1 * mh1 + c_w2 * mh2);
            et = sat12(c_tt + corr);
            em = sat12(c_tm + corr);
            eb = sat12(c_tb + corr);
            t = (mdl[c_st] >= et) ? 1 : 0;
            m = (mdl[c_sm] >= em) ? 1 : 0;
            b = (mdl[c_sb] >= eb) ? 1 : 0;
            case ({t[0], m[0], b[0]})
                3'b000: s = 0;
                3'b001: s = 1;
                3'b011: s = 2;
                3'b111: s = 3;
                default: begin s = m ? 2 : 1; merr = 1; end
            endcase
            mh2 = mh1;
            mh1 = lvl(s);
            if (c_pl != 0) code = s;
            else code = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 2;
        end
    endtask

    task automatic step(input bit v, input int smp, input string tag);
        bit e;
        int code;
        @(negedge clk);
        chk("R2", int'(sym_valid), int'(d2_v));
        if (d2_v) chk(d2_tag, int'(sym_out), d2_code);
        chk("R4", int'(code_err), d2_err);
        d2_v = d1_v; d2_code = d1_code; d2_err = d1_err; d2_tag = d1_tag;
        in_valid  = v;
        in_sample = 12'(smp);
        thr_top = 12'(c_tt); thr_mid = 12'(c_tm); thr_bot = 12'(c_tb);
        skew_top = 2'(c_st); skew_mid = 2'(c_sm); skew_bot = 2'(c_sb);
        tap_w1 = 12'(c_w1); tap_w2 = 12'(c_w2); plain_bin = c_pl[0];
        e = 0; code = 0;
        if (v) model_accept(smp, e, code);
        d1_v = e; d1_code = code; d1_err = merr; d1_tag = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1", int'(sym_valid), 0);
        chk("R1", int'(code_err), 0);
        chk("R1", int'(sym_out), 0);
    endtask

    task automatic set_clean();
        c_tt = 1024; c_tm = 0; c_tb = -1024;
        c_st = 0; c_sm = 0; c_sb = 0; c_w1 = 0; c_w2 = 0; c_pl = 0;
    endtask

    task automatic randomize_cfg(input int mode);
        case (mode)
            0: begin
                c_tt = rnd_rng(700, 1300); c_tm = rnd_rng(-200, 200); c_tb = rnd_rng(-1300, -700);
                c_w1 = 0; c_w2 = 0; c_st = 0; c_sm = 0; c_sb = 0;
            end
            1: begin
                c_w1 = rnd_rng(-300, 300); c_w2 = rnd_rng(-300, 300);
            end
            2: begin
                c_st = rnd_rng(0, 3); c_sm = rnd_rng(0, 3); c_sb = rnd_rng(0, 3);
            end
            3: begin
                c_w1 = ($urandom % 2) ? 2047 : -2048; c_w2 = ($urandom % 2) ? 2047 : -2048;
                c_tt = rnd_rng(1900, 2047); c_tm = rnd_rng(-100, 100); c_tb = rnd_rng(-2048, -1900);
            end
            default: begin
                c_tt = rnd12(); c_tm = rnd12(); c_tb = rnd12();
                c_st = rnd_rng(0, 3); c_sm = rnd_rng(0, 3); c_sb = rnd_rng(0, 3);
                c_w1 = rnd12(); c_w2 = rnd12(); c_pl = int'($urandom % 2);
            end
        endcase
    endtask

    task automatic run_seg(input int mode, input int n, input int pv, input string tag);
        for (int i = 0; i < n; i++) begin
            bit v;
            int smp;
            v = (int'($urandom % 100) < pv);
            if (mode == 4) c_pl = int'($urandom % 2);
            else if (mode >= 5 || (i % 7) == 0) randomize_cfg(mode);
            smp = (mode == 3) ? (($urandom % 2) ? rnd_rng(1800, 2047) : rnd_rng(-2048, -1800)) : rnd12();
            step(v, smp, tag);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd7713));
        set_clean();
        model_reset();
        do_reset();

        // R2: three samples do not fill the line
        for (int i = 0; i < 3; i++) step(1, 1500, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, "R2");
        // R3: fourth sample gives the first decision; sweep the four regions
        step(1, 1500, "R3");
        step(1, 400, "R3");
        step(1, -400, "R3");
        step(1, -1500, "R3");
        step(1, 1024, "R3");
        step(1, 1023, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, "R3");

        run_seg(0, 300, 85, "R3");
        set_clean();
        run_seg(1, 400, 90, "R6");

        // R4: inverted thresholds give pattern 110, fallback to centre
        set_clean();
        c_tt = -500; c_tm = 0; c_tb = 500;
        step(1, 100, "R4");
        step(1, -100, "R4");
        set_clean();
        step(1, 1500, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, "R4");

        set_clean();
        run_seg(2, 500, 90, "R5");
        run_seg(3, 400, 90, "R7");

        do_reset();
        set_clean();
        run_seg(4, 500, 90, "R8");
        run_seg(5, 600, 50, "R9");
        run_seg(6, 600, 20, "R10");
        run_seg(7, 1500, 80, "R6");

        for (int i = 0; i < 3; i++) step(0, 0, "R10");
        report();
        $finish;
    end

endmodule